// File: doc/BRIEF.md
# Answer-to-Reset Stream Parser

This block sits behind the character receiver of a contact smart-card reader and interprets the answer a card sends after reset. It receives the raw initial character on its own strobe. From that character it decides whether the card uses the direct or the inverse bit convention. Every later byte arrives on a second strobe in raw form, with bit 0 being the first data bit on the line and a high line level read as 1. The parser decodes each byte with the chosen convention.

Which byte comes next is decided as the bytes arrive. The format byte and each protocol-indicator byte carry a four-bit presence map for the next group of interface bytes, and the format byte also carries the historical byte count. The parser walks this chain, skips over the historical bytes, and expects a trailing XOR check byte only when some protocol other than type 0 is offered. At the end it holds the clock-rate code, the baud-divisor code, the extra guard time, the waiting-time integer, and a bitmask of offered protocol types. It pulses a done flag for one cycle and raises error flags for a bad initial character, a bad check byte or an answer that is too long.

Top module: `atrParse`

## Requirements
- R1: A raw initial character of 0x3B selects the direct convention and 0x03 selects the inverse convention. Any other value sets `errTs` and pulses `atrDone` in the cycle after the strobe.
- R2: Under the inverse convention, each later byte is decoded as the bit-reversed complement of its raw value (decoded bit i = NOT raw bit 7-i). Under the direct convention, the raw value is used unchanged.
- R3: In the format byte, bits 4, 5, 6 and 7 announce the first interface group's A, B, C and D bytes, which arrive in that order. Bits 3:0 give the historical byte count K, and K is shown on `histCount`.
- R4: Each D byte uses bits 7:4 as the presence map for the next group. When a group has no D byte, no further interface bytes follow, and the historical bytes come next.
- R5: The first group's A byte loads `fiCode` from bits 7:4 and `diCode` from bits 3:0. The first group's C byte loads `guardN`. The second group's C byte loads `waitWi`.
- R6: A new valid initial character restores the defaults: fiCode 1, diCode 1, guardN 0, waitWi 10, protoMask 0x0001 (type 0). An absent byte leaves its default in place.
- R7: The low nibble T of every D byte sets bit T of `protoMask`. The first D byte replaces the type-0 default.
- R8: A check byte is expected exactly when some D byte carries a T that is not 0. `errCheck` is set when the XOR of all decoded bytes from the format byte through the check byte is not zero.
- R9: At most 32 bytes may follow the initial character. Receiving a 33rd byte sets `errOverflow` and pulses `atrDone`.
- R10: `atrDone` is a one-cycle pulse in the cycle after the final byte is accepted. Bytes that arrive when no answer is in progress are ignored.
- R11: A valid initial character restarts parsing at any point, including during an unfinished answer. If the initial character strobe and the byte strobe are high in the same cycle, the initial character takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tsValid | input | 1 | Raw initial character strobe |
| tsRaw | input | 8 | Raw initial character, first line bit in bit 0 |
| byteValid | input | 1 | Raw subsequent byte strobe |
| byteRaw | input | 8 | Raw subsequent byte, first line bit in bit 0 |
| atrDone | output | 1 | One-cycle pulse at the end of an answer |
| inverseConv | output | 1 | 1 when the inverse convention was detected |
| errTs | output | 1 | Initial character was not recognised |
| errCheck | output | 1 | Check byte XOR mismatch |
| errOverflow | output | 1 | More than the allowed number of bytes |
| fiCode | output | 4 | Clock-rate conversion code |
| diCode | output | 4 | Baud-rate adjustment code |
| guardN | output | 8 | Extra guard time |
| waitWi | output | 8 | Waiting-time integer |
| histCount | output | 4 | Historical byte count |
| protoMask | output | 16 | Offered protocol types, one bit per type |

## Verification
A table of answers exercises the main function with several shapes of answer:
- a bare format byte, which tests the defaults;
- an answer with only A1 plus historical bytes, which shows K is honoured without a check byte;
- an inverse-coded answer with A1 and C1, which separates the two conventions;
- chained answers that offer T=1 and T=15, with a good check byte and with a bad one, which shows the check byte is required and the XOR is tested;
- a two-group chain offering T=0 and then T=1, which shows the protocol bitmask accumulates.

Directed cases then cover an unrecognised initial character, an endless chain of D bytes that runs past 32 bytes, stray bytes sent after completion, and a restart in the middle of an answer.

// File: rtl/atrPkg.sv
package atrPkg;

  localparam logic [7:0] TS_DIRECT_RAW  = 8'h3B;
  localparam logic [7:0] TS_INVERSE_RAW = 8'h03;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FMT,
    PH_IFACE,
    PH_HIST,
    PH_TCK
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic startNew;
    logic tsBad;
    logic capFmt;
    logic capTa1;
    logic capTc1;
    logic capTc2;
    logic capTd;
    logic capTck;
    logic accXor;
    logic overflow;
    logic finish;
  } strobe_t;

  // inverse convention: complemented levels, most significant bit first
  function automatic logic [7:0] decodeByte(input logic [7:0] raw, input logic inv);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      d[i] = inv ? ~raw[7-i] : raw[i];
    end
    return d;
  endfunction

  // phase that follows once the interface map is known
  function automatic phase_e phaseAfter(input logic [3:0] pend, input logic [3:0] hist,
                                        input logic needTck);
    if (pend != 4'd0)      return PH_IFACE;
    else if (hist != 4'd0) return PH_HIST;
    else if (needTck)      return PH_TCK;
    else                   return PH_IDLE;
  endfunction

endpackage

// File: rtl/atrCtrl.sv
module atrCtrl
  import atrPkg::*;
#(
  parameter int MAX_CHARS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tsValid,
  input  logic       tsOk,
  input  logic       byteValid,
  input  logic [7:0] curByte,
  output strobe_t    stb
);

  localparam int CNT_W = $clog2(MAX_CHARS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CHARS);

  phase_e           phase, phaseNxt;
  logic [3:0]       pend, pendNxt;
  logic [3:0]       histLeft, histNxt;
  logic [1:0]       grp, grpNxt;
  logic             needTck, needTckNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_comb begin
    stb        = '0;
    phaseNxt   = phase;
    pendNxt    = pend;
    histNxt    = histLeft;
    grpNxt     = grp;
    needTckNxt = needTck;
    cntNxt     = cnt;
    if (tsValid) begin
      stb.startNew = 1'b1;
      cntNxt       = '0;
      pendNxt      = '0;
      histNxt      = '0;
      grpNxt       = '0;
      needTckNxt   = 1'b0;
      if (tsOk) begin
        phaseNxt = PH_FMT;
      end else begin
        stb.tsBad  = 1'b1;
        stb.finish = 1'b1;
        phaseNxt   = PH_IDLE;
      end
    end else if (byteValid && phase != PH_IDLE) begin
      if (cnt == CNT_MAX) begin
        stb.overflow = 1'b1;
        phaseNxt     = PH_IDLE;
      end else begin
        cntNxt     = cnt + 1'b1;
        stb.accXor = 1'b1;
        case (phase)
          PH_FMT: begin
            stb.capFmt = 1'b1;
            pendNxt    = curByte[7:4];
            histNxt    = curByte[3:0];
            grpNxt     = 2'd1;
            phaseNxt   = phaseAfter(curByte[7:4], curByte[3:0], 1'b0);
          end
          PH_IFACE: begin
            if (pend[0]) begin
              pendNxt    = pend & 4'b1110;
              stb.capTa1 = (grp == 2'd1);
            end else if (pend[1]) begin
              pendNxt = pend & 4'b1100;
            end else if (pend[2]) begin
              pendNxt    = pend & 4'b1000;
              stb.capTc1 = (grp == 2'd1);
              stb.capTc2 = (grp == 2'd2);
            end else begin
              stb.capTd  = 1'b1;
              pendNxt    = curByte[7:4];
              needTckNxt = needTck | (curByte[3:0] != 4'd0);
              grpNxt     = (grp == 2'd3) ? grp : grp + 1'b1;
            end
            phaseNxt = phaseAfter(pendNxt, histLeft, needTckNxt);
          end
          PH_HIST: begin
            histNxt  = histLeft - 1'b1;
            phaseNxt = phaseAfter(4'd0, histNxt, needTck);
          end
          PH_TCK: begin
            stb.capTck = 1'b1;
            phaseNxt   = PH_IDLE;
          end
          default: phaseNxt = PH_IDLE;
        endcase
      end
      if (phaseNxt == PH_IDLE) stb.finish = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      pend     <= '0;
      histLeft <= '0;
      grp      <= '0;
      needTck  <= 1'b0;
      cnt      <= '0;
    end else begin
      phase    <= phaseNxt;
      pend     <= pendNxt;
      histLeft <= histNxt;
      grp      <= grpNxt;
      needTck  <= needTckNxt;
      cnt      <= cntNxt;
    end
  end

  // R9: the stored byte count never passes the limit
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_MAX);

  // R10: bytes outside an answer leave the parser idle
  p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && byteValid && !tsValid) |=> (phase == PH_IDLE));

  // R11: a valid initial character always restarts at the format byte
  p_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    (tsValid && tsOk) |=> (phase == PH_FMT && cnt == '0));

endmodule

// File: rtl/atrDatapath.sv
module atrDatapath
  import atrPkg::*;
#(
  parameter logic [3:0] DEF_FI = 4'd1,
  parameter logic [3:0] DEF_DI = 4'd1,
  parameter logic [7:0] DEF_WI = 8'd10
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [7:0]  tsRaw,
  input  logic [7:0]  byteRaw,
  output logic        tsOk,
  output logic [7:0]  curByte,
  output logic        atrDone,
  output logic        inverseConv,
  output logic        errTs,
  output logic        errCheck,
  output logic        errOverflow,
  output logic [3:0]  fiCode,
  output logic [3:0]  diCode,
  output logic [7:0]  guardN,
  output logic [7:0]  waitWi,
  output logic [3:0]  histCount,
  output logic [15:0] protoMask
);

  localparam logic [15:0] MASK_T0 = 16'h0001;

  logic       sawTd;
  logic [7:0] xorAcc;
  logic [7:0] xorNext;

  assign tsOk    = (tsRaw == TS_DIRECT_RAW) || (tsRaw == TS_INVERSE_RAW);
  assign curByte = decodeByte(byteRaw, inverseConv);
  assign xorNext = xorAcc ^ curByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      atrDone     <= 1'b0;
      inverseConv <= 1'b0;
      errTs       <= 1'b0;
      errCheck    <= 1'b0;
      errOverflow <= 1'b0;
      fiCode      <= DEF_FI;
      diCode      <= DEF_DI;
      guardN      <= '0;
      waitWi      <= DEF_WI;
      histCount   <= '0;
      protoMask   <= MASK_T0;
      sawTd       <= 1'b0;
      xorAcc      <= '0;
    end else begin
      atrDone <= stb.finish | stb.overflow;
      if (stb.startNew) begin
        inverseConv <= (tsRaw == TS_INVERSE_RAW);
        errTs       <= stb.tsBad;
        errCheck    <= 1'b0;
        errOverflow <= 1'b0;
        fiCode      <= DEF_FI;
        diCode      <= DEF_DI;
        guardN      <= '0;
        waitWi      <= DEF_WI;
        histCount   <= '0;
        protoMask   <= MASK_T0;
        sawTd       <= 1'b0;
        xorAcc      <= '0;
      end else begin
        if (stb.accXor) xorAcc <= xorNext;
        if (stb.capFmt) histCount <= curByte[3:0];
        if (stb.capTa1) begin
          fiCode <= curByte[7:4];
          diCode <= curByte[3:0];
        end
        if (stb.capTc1) guardN <= curByte;
        if (stb.capTc2) waitWi <= curByte;
        if (stb.capTd) begin
          sawTd <= 1'b1;
          if (sawTd) protoMask <= protoMask | (16'd1 << curByte[3:0]);
          else       protoMask <= 16'd1 << curByte[3:0];
        end
        if (stb.capTck)   errCheck    <= (xorNext != 8'd0);
        if (stb.overflow) errOverflow <= 1'b1;
      end
    end
  end

  // R1: an unknown initial character flags the error and ends the answer
  p_ts_err_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startNew && !tsOk) |=> (errTs && atrDone));

  // R6: a restart puts every parameter back to its default
  p_defaults_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startNew && tsOk) |=> (fiCode == DEF_FI && diCode == DEF_DI &&
                                guardN == 8'd0 && waitWi == DEF_WI && protoMask == MASK_T0));

  // R7: the announced protocol type is present in the mask afterwards
  p_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capTd && !stb.startNew) |=> protoMask[$past(curByte[3:0])]);

  // R8: a nonzero running XOR at the check byte is reported
  p_check_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capTck && !stb.startNew && (xorAcc != curByte)) |=> errCheck);

endmodule

// File: rtl/atrParse.sv
module atrParse
  import atrPkg::*;
#(
  parameter int         MAX_CHARS = 32,
  parameter logic [3:0] DEF_FI    = 4'd1,
  parameter logic [3:0] DEF_DI    = 4'd1,
  parameter logic [7:0] DEF_WI    = 8'd10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tsValid,
  input  logic [7:0]  tsRaw,
  input  logic        byteValid,
  input  logic [7:0]  byteRaw,
  output logic        atrDone,
  output logic        inverseConv,
  output logic        errTs,
  output logic        errCheck,
  output logic        errOverflow,
  output logic [3:0]  fiCode,
  output logic [3:0]  diCode,
  output logic [7:0]  guardN,
  output logic [7:0]  waitWi,
  output logic [3:0]  histCount,
  output logic [15:0] protoMask
);

  strobe_t    stb;
  logic       tsOk;
  logic [7:0] curByte;

  atrCtrl #(.MAX_CHARS(MAX_CHARS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tsValid   (tsValid),
    .tsOk      (tsOk),
    .byteValid (byteValid),
    .curByte   (curByte),
    .stb       (stb)
  );

  atrDatapath #(.DEF_FI(DEF_FI), .DEF_DI(DEF_DI), .DEF_WI(DEF_WI)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .tsRaw       (tsRaw),
    .byteRaw     (byteRaw),
    .tsOk        (tsOk),
    .curByte     (curByte),
    .atrDone     (atrDone),
    .inverseConv (inverseConv),
    .errTs       (errTs),
    .errCheck    (errCheck),
    .errOverflow (errOverflow),
    .fiCode      (fiCode),
    .diCode      (diCode),
    .guardN      (guardN),
    .waitWi      (waitWi),
    .histCount   (histCount),
    .protoMask   (protoMask)
  );

endmodule

// File: tb/atrParse_tb.sv
module atrParse_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tsValid = 1'b0;
  logic [7:0]  tsRaw = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteRaw = '0;
  logic        atrDone, inverseConv, errTs, errCheck, errOverflow;
  logic [3:0]  fiCode, diCode, histCount;
  logic [7:0]  guardN, waitWi;
  logic [15:0] protoMask;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  atrParse u_dut (
    .clk(clk), .rstN(rstN), .tsValid(tsValid), .tsRaw(tsRaw),
    .byteValid(byteValid), .byteRaw(byteRaw), .atrDone(atrDone),
    .inverseConv(inverseConv), .errTs(errTs), .errCheck(errCheck),
    .errOverflow(errOverflow), .fiCode(fiCode), .diCode(diCode),
    .guardN(guardN), .waitWi(waitWi), .histCount(histCount), .protoMask(protoMask)
  );

  typedef struct packed {
    logic             inv;
    logic [3:0]       len;
    logic [0:11][7:0] bytes;
    logic [3:0]       fi;
    logic [3:0]       di;
    logic [7:0]       n;
    logic [7:0]       wi;
    logic [15:0]      mask;
    logic [3:0]       k;
    logic             errC;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // bare format byte
    '{1'b0, 4'd1, {8'h00, 88'h0}, 4'd1, 4'd1, 8'd0, 8'd10, 16'h0001, 4'd0, 1'b0},
    // A1 plus two historical bytes, only T=0
    '{1'b0, 4'd4, {8'h12, 8'h95, 8'h41, 8'h42, 64'h0}, 4'd9, 4'd5, 8'd0, 8'd10, 16'h0001, 4'd2, 1'b0},
    // inverse convention, A1 and C1
    '{1'b1, 4'd3, {8'h50, 8'h11, 8'h05, 72'h0}, 4'd1, 4'd1, 8'd5, 8'd10, 16'h0001, 4'd0, 1'b0},
    // D1 (T=1) -> C2, D2 (T=15), one historical byte, good check byte
    '{1'b0, 4'd6, {8'h81, 8'hC1, 8'h20, 8'h0F, 8'h55, 8'h3A, 48'h0}, 4'd1, 4'd1, 8'd0, 8'h20, 16'h8002, 4'd1, 1'b0},
    // same with bad check byte
    '{1'b0, 4'd6, {8'h81, 8'hC1, 8'h20, 8'h0F, 8'h55, 8'h3B, 48'h0}, 4'd1, 4'd1, 8'd0, 8'h20, 16'h8002, 4'd1, 1'b1},
    // full first group, T=0 then T=1
    '{1'b0, 4'd7, {8'hF0, 8'h18, 8'h00, 8'hFF, 8'h80, 8'h01, 8'h96, 40'h0}, 4'd1, 4'd8, 8'd255, 8'd10, 16'h0003, 4'd0, 1'b0},
    // inverse copy of the chained answer
    '{1'b1, 4'd6, {8'h81, 8'hC1, 8'h20, 8'h0F, 8'h55, 8'h3A, 48'h0}, 4'd1, 4'd1, 8'd0, 8'h20, 16'h8002, 4'd1, 1'b0}
  };

  // inverse line coding of a data byte, derived from the convention rule
  function automatic logic [7:0] lineCode(input logic [7:0] d, input logic inv);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = inv ? ~d[i] : d[7-i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendTs(input logic [7:0] raw, output logic doneSeen);
    @(negedge clk);
    tsValid = 1'b1;
    tsRaw   = raw;
    @(negedge clk);
    tsValid  = 1'b0;
    doneSeen = atrDone;
  endtask

  task automatic sendByte(input logic [7:0] raw, output logic doneSeen);
    @(negedge clk);
    byteValid = 1'b1;
    byteRaw   = raw;
    @(negedge clk);
    byteValid = 1'b0;
    doneSeen  = atrDone;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic d;
    int doneAt;
    int earlyDone;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R6, R10)
    check("R10 reset done", {31'd0, atrDone}, 32'd0);
    check("R6 reset errors", {29'd0, errTs, errCheck, errOverflow}, 32'd0);
    check("R6 reset fi/wi/mask", {fiCode, diCode, waitWi, protoMask}, {4'd1, 4'd1, 8'd10, 16'h0001});

    // table of answers (R2..R8, R10)
    for (int v = 0; v < NV; v++) begin
      vec_t e;
      e = VECS[v];
      earlyDone = 0;
      sendTs(e.inv ? 8'h03 : 8'h3B, d);
      check("R1 convention", {31'd0, inverseConv}, {31'd0, e.inv});
      for (int j = 0; j < int'(e.len); j++) begin
        sendByte(lineCode(e.bytes[j], e.inv), d);
        if (j < int'(e.len) - 1 && d) earlyDone++;
      end
      check("R10 done after last byte", {31'd0, d}, 32'd1);
      check("R3 R4 R8 no early done", earlyDone, 0);
      check("R5 fi di", {fiCode, diCode}, {e.fi, e.di});
      check("R5 guard and wait", {guardN, waitWi}, {e.n, e.wi});
      check("R7 protocol mask", {16'd0, protoMask}, {16'd0, e.mask});
      check("R3 historical count", {28'd0, histCount}, {28'd0, e.k});
      check("R8 check error", {31'd0, errCheck}, {31'd0, e.errC});
      check("R2 no ts error", {31'd0, errTs}, 32'd0);
      sendByte(lineCode(8'hA7, e.inv), d);
      check("R10 stray byte ignored", {d, fiCode, guardN}, {1'b0, e.fi, e.n});
    end

    // R1: unknown initial character
    sendTs(8'h5A, d);
    check("R1 bad ts done", {31'd0, d}, 32'd1);
    check("R1 bad ts flag", {31'd0, errTs}, 32'd1);
    sendByte(8'h10, d);
    check("R10 byte after bad ts", {31'd0, d}, 32'd0);

    // R9: endless chain of D bytes
    sendTs(8'h3B, d);
    doneAt = 0;
    for (int i = 1; i <= 40; i++) begin
      sendByte(8'h80, d);
      if (d) doneAt = (doneAt == 0) ? i : -1;
    end
    check("R9 done on 33rd byte", doneAt, 33);
    check("R9 overflow flag", {30'd0, errOverflow, errCheck}, {30'd0, 1'b1, 1'b0});

    // R11: restart in the middle of an answer
    sendTs(8'h3B, d);
    sendByte(8'h10, d);
    sendTs(8'h03, d);
    check("R11 restart flags", {29'd0, errOverflow, errTs, inverseConv}, {29'd0, 1'b0, 1'b0, 1'b1});
    sendByte(lineCode(8'h00, 1'b1), d);
    check("R11 restarted answer done", {d, fiCode}, {1'b1, 4'd1});

    // R11: initial character wins over a simultaneous byte
    @(negedge clk);
    tsValid = 1'b1; tsRaw = 8'h3B; byteValid = 1'b1; byteRaw = 8'h00;
    @(negedge clk);
    tsValid = 1'b0; byteValid = 1'b0;
    check("R11 ts priority no done", {31'd0, atrDone}, 32'd0);
    sendByte(8'h00, d);
    check("R11 ts priority then done", {31'd0, d}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule